// File: doc/BRIEF.md
# Soft-Bit Depuncturer

This block sits between a coherent PSK demodulator and a rate-1/2, constraint-length-7 Viterbi decoder. Each accepted input symbol carries two 4-bit soft samples, one from the in-phase arm and one from the quadrature arm. Together they make a serial stream of transmitted code bits. The block walks that stream against the deletion pattern of the selected code rate. It rebuilds the mother-code branch pairs: X belongs to generator 171 (octal) and Y to generator 133 (octal). Every bit the transmitter deleted is replaced by a mid-scale erasure value and flagged.

One symbol can complete one or two branch pairs, so the output has two registered lanes. The lanes are filled in order. Each pair carries a flag on the last position of its puncturing period. A swap input exchanges the roles of the two arms, which lets an outer search try the spectrally inverted hypothesis. Changing the rate select restarts the walk at the first position of the period.

Top module: `sdp_depuncturer`

## Requirements
- R1: The 3-bit rate select picks the deletion pattern, listed as position 1 first with 1 = transmitted. 0 = 1/2 (X 1, Y 1), 1 = 2/3 (X 10, Y 11), 2 = 3/4 (X 101, Y 110), 3 = 4/5 (X 1000, Y 1111), 4 = 5/6 (X 10101, Y 11010), 5 = 6/7 (X 100101, Y 111010), 6 = 7/8 (X 1000101, Y 1111010), 7 = 8/9 (X 10001011, Y 11110100). The period length is the code plus one.
- R2: An accepted symbol supplies two code bits, first the I sample and then the Q sample. The code bits fill the transmitted slots in position order, with X before Y inside a position. A partial position carries over into the next symbol.
- R3: A deleted slot is output as 4'b1000 with its erasure flag set. A transmitted slot has its flag clear. No pair has both slots erased.
- R4: At rate code 0, each accepted symbol gives exactly one pair, with X = I, Y = Q and no erasures.
- R5: Pairs appear one cycle after the symbol's clock edge. Lane 0 holds the earlier pair and lane 1 the later one. Lane 1 is valid only together with lane 0. Every accepted symbol yields one or two pairs.
- R6: The period-end flag is set on a pair exactly when it holds the last position of the selected period.
- R7: With swap high, the Q sample is taken as the first code bit and the I sample as the second.
- R8: In a cycle where the rate select differs from the rate in use, the symbol is discarded, any partial position is dropped, and no lane is valid in the next cycle. The walk then restarts at position 1 under the new rate.
- R9: Synchronous active-high reset clears both lanes and the walk position. The rate select seen during reset is adopted with no discarded symbol.
- R10: A cycle without input valid gives no valid lanes and leaves the walk state untouched. After an idle gap the stream continues where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input symbol strobe |
| in_i | input | 4 | In-phase soft sample |
| in_q | input | 4 | Quadrature soft sample |
| rate_sel | input | 3 | Code rate select (R1) |
| swap_iq | input | 1 | Exchange the arms' order |
| o0_valid | output | 1 | Lane 0 pair valid |
| o0_x | output | 4 | Lane 0 X soft value |
| o0_y | output | 4 | Lane 0 Y soft value |
| o0_ex | output | 1 | Lane 0 X erased |
| o0_ey | output | 1 | Lane 0 Y erased |
| o0_eop | output | 1 | Lane 0 pair ends the period |
| o1_valid | output | 1 | Lane 1 pair valid |
| o1_x | output | 4 | Lane 1 X soft value |
| o1_y | output | 4 | Lane 1 Y soft value |
| o1_ex | output | 1 | Lane 1 X erased |
| o1_ey | output | 1 | Lane 1 Y erased |
| o1_eop | output | 1 | Lane 1 pair ends the period |

## Verification
Every result of this block is due in the cycle after the rising edge that samples the symbol. This covers the pairs in both lanes, the erasure and period-end flags, and the gap that follows a rate change. The bench drives inputs on the falling edge and updates its queue-based model at the same moment. At the next falling edge, just after the rising edge the design registers on, it compares both lanes with the model. Carried partial positions, idle gaps and restarts after a rate change are therefore all checked in the exact cycle they should show.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int SOFT_W = 4;
    localparam int POS_W  = 3;
    localparam int MAXLEN = 1 << POS_W;
    localparam logic [SOFT_W-1:0] ERASE_VAL = {1'b1, {(SOFT_W-1){1'b0}}};

    typedef enum logic [POS_W-1:0] {
        RT_1_2, RT_2_3, RT_3_4, RT_4_5, RT_5_6, RT_6_7, RT_7_8, RT_8_9
    } rate_e;

    // one rebuilt mother-code branch pair
    typedef struct packed {
        logic [SOFT_W-1:0] x;
        logic [SOFT_W-1:0] y;
        logic              ex;
        logic              ey;
        logic              eop;
    } pair_t;

    // walk state: position in period, X-held phase, held X sample
    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic              ph;
        logic [SOFT_W-1:0] held;
    } trk_t;

    // deletion patterns, left aligned, position 1 in the MSB
    function automatic logic mask_x(rate_e r, logic [POS_W-1:0] p);
        logic [MAXLEN-1:0] m;
        case (r)
            RT_1_2:  m = 8'b1000_0000;
            RT_2_3:  m = 8'b1000_0000;
            RT_3_4:  m = 8'b1010_0000;
            RT_4_5:  m = 8'b1000_0000;
            RT_5_6:  m = 8'b1010_1000;
            RT_6_7:  m = 8'b1001_0100;
            RT_7_8:  m = 8'b1000_1010;
            default: m = 8'b1000_1011;
        endcase
        return m[MAXLEN-1-int'(p)];
    endfunction

    function automatic logic mask_y(rate_e r, logic [POS_W-1:0] p);
        logic [MAXLEN-1:0] m;
        case (r)
            RT_1_2:  m = 8'b1000_0000;
            RT_2_3:  m = 8'b1100_0000;
            RT_3_4:  m = 8'b1100_0000;
            RT_4_5:  m = 8'b1111_0000;
            RT_5_6:  m = 8'b1101_0000;
            RT_6_7:  m = 8'b1110_1000;
            RT_7_8:  m = 8'b1111_0100;
            default: m = 8'b1111_0100;
        endcase
        return m[MAXLEN-1-int'(p)];
    endfunction

endpackage

// File: rtl/sdp_rate_ctl.sv
module sdp_rate_ctl
    import sdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] rate_sel,
    output rate_e            rate_q,
    output logic             rate_chg
);

    assign rate_chg = !rst && (rate_sel != rate_q);

    always_ff @(posedge clk) begin
        if (rst || rate_chg) rate_q <= rate_e'(rate_sel);
    end

    // R8: after a detected change the new code is in use
    p_rate_follow_r8: assert property (@(posedge clk) disable iff (rst)
        rate_chg |=> (rate_q == $past(rate_sel)));

endmodule

// File: rtl/sdp_bit_step.sv
module sdp_bit_step
    import sdp_pkg::*;
(
    input  rate_e             rate,
    input  trk_t              cur,
    input  logic [SOFT_W-1:0] bit_in,
    output trk_t              nxt,
    output logic              emit,
    output pair_t             pair
);

    logic xm, ym, last;

    always_comb begin
        xm   = mask_x(rate, cur.pos);
        ym   = mask_y(rate, cur.pos);
        last = (cur.pos == POS_W'(rate));
        nxt  = cur;
        emit = 1'b0;
        pair.x   = ERASE_VAL;
        pair.y   = ERASE_VAL;
        pair.ex  = 1'b1;
        pair.ey  = 1'b1;
        pair.eop = last;
        if (cur.ph) begin
            pair.x  = cur.held;
            pair.ex = 1'b0;
            pair.y  = bit_in;
            pair.ey = 1'b0;
            emit    = 1'b1;
        end else if (xm && ym) begin
            nxt.ph   = 1'b1;
            nxt.held = bit_in;
        end else if (xm) begin
            pair.x  = bit_in;
            pair.ex = 1'b0;
            emit    = 1'b1;
        end else begin
            pair.y  = bit_in;
            pair.ey = 1'b0;
            emit    = 1'b1;
        end
        if (emit) begin
            nxt.ph  = 1'b0;
            nxt.pos = last ? '0 : cur.pos + 1'b1;
        end
    end

endmodule

// File: rtl/sdp_lane_pack.sv
module sdp_lane_pack
    import sdp_pkg::*;
(
    input  logic [1:0]  emit,
    input  pair_t [1:0] pair,
    output logic        l0_v,
    output pair_t       l0,
    output logic        l1_v,
    output pair_t       l1
);

    always_comb begin
        l0_v = emit[0] | emit[1];
        l0   = emit[0] ? pair[0] : pair[1];
        l1_v = emit[0] & emit[1];
        l1   = pair[1];
    end

endmodule

// File: rtl/sdp_depuncturer.sv
module sdp_depuncturer
    import sdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SOFT_W-1:0] in_i,
    input  logic [SOFT_W-1:0] in_q,
    input  logic [POS_W-1:0]  rate_sel,
    input  logic              swap_iq,
    output logic              o0_valid,
    output logic [SOFT_W-1:0] o0_x,
    output logic [SOFT_W-1:0] o0_y,
    output logic              o0_ex,
    output logic              o0_ey,
    output logic              o0_eop,
    output logic              o1_valid,
    output logic [SOFT_W-1:0] o1_x,
    output logic [SOFT_W-1:0] o1_y,
    output logic              o1_ex,
    output logic              o1_ey,
    output logic              o1_eop
);

    localparam int NBITS = 2;

    rate_e             rate_q;
    logic              rate_chg;
    trk_t              trk_q;
    trk_t              chain [NBITS+1];
    logic [SOFT_W-1:0] bits  [NBITS];
    logic [NBITS-1:0]  em;
    pair_t [NBITS-1:0] pr;
    logic              l0_v, l1_v;
    pair_t             l0, l1;
    logic              v0_q, v1_q;
    pair_t             p0_q, p1_q;

    sdp_rate_ctl u_rate (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .rate_q   (rate_q),
        .rate_chg (rate_chg)
    );

    assign bits[0]  = swap_iq ? in_q : in_i;
    assign bits[1]  = swap_iq ? in_i : in_q;
    assign chain[0] = trk_q;

    for (genvar k = 0; k < NBITS; k++) begin : g_step
        sdp_bit_step u_step (
            .rate   (rate_q),
            .cur    (chain[k]),
            .bit_in (bits[k]),
            .nxt    (chain[k+1]),
            .emit   (em[k]),
            .pair   (pr[k])
        );
    end

    sdp_lane_pack u_pack (
        .emit (em),
        .pair (pr),
        .l0_v (l0_v),
        .l0   (l0),
        .l1_v (l1_v),
        .l1   (l1)
    );

    always_ff @(posedge clk) begin
        if (rst || rate_chg) begin
            trk_q <= '0;
            v0_q  <= 1'b0;
            v1_q  <= 1'b0;
            p0_q  <= '0;
            p1_q  <= '0;
        end else begin
            v0_q <= in_valid & l0_v;
            v1_q <= in_valid & l1_v;
            if (in_valid) begin
                trk_q <= chain[NBITS];
                p0_q  <= l0;
                p1_q  <= l1;
            end
        end
    end

    assign o0_valid = v0_q;
    assign o0_x     = p0_q.x;
    assign o0_y     = p0_q.y;
    assign o0_ex    = p0_q.ex;
    assign o0_ey    = p0_q.ey;
    assign o0_eop   = p0_q.eop;
    assign o1_valid = v1_q;
    assign o1_x     = p1_q.x;
    assign o1_y     = p1_q.y;
    assign o1_ex    = p1_q.ex;
    assign o1_ey    = p1_q.ey;
    assign o1_eop   = p1_q.eop;

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !o0_valid && !o1_valid);

    p_accept_emits_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rate_chg) |=> o0_valid);

    p_lane_order_r5: assert property (@(posedge clk) disable iff (rst)
        o1_valid |-> o0_valid);

    p_chg_gap_r8: assert property (@(posedge clk) disable iff (rst)
        rate_chg |=> !o0_valid && !o1_valid);

    p_half_clean_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rate_chg && rate_q == RT_1_2)
        |=> !o1_valid && !o0_ex && !o0_ey && o0_eop);

    p_single_erase_r3: assert property (@(posedge clk) disable iff (rst)
        o0_valid |-> !(o0_ex && o0_ey));

    p_erase_mid_r3: assert property (@(posedge clk) disable iff (rst)
        (o1_valid && o1_ey) |-> (o1_y == ERASE_VAL));

endmodule

// File: tb/sdp_depuncturer_tb.sv
`timescale 1ns/1ps
module sdp_depuncturer_tb_top;

    localparam int ERASE = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] in_i = '0;
    logic [3:0] in_q = '0;
    logic [2:0] rate_sel = '0;
    logic       swap_iq = 1'b0;
    logic       o0_valid, o0_ex, o0_ey, o0_eop;
    logic       o1_valid, o1_ex, o1_ey, o1_eop;
    logic [3:0] o0_x, o0_y, o1_x, o1_y;

    always #4 clk = ~clk;

    sdp_depuncturer dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .rate_sel(rate_sel), .swap_iq(swap_iq),
        .o0_valid(o0_valid), .o0_x(o0_x), .o0_y(o0_y), .o0_ex(o0_ex),
        .o0_ey(o0_ey), .o0_eop(o0_eop),
        .o1_valid(o1_valid), .o1_x(o1_x), .o1_y(o1_y), .o1_ex(o1_ex),
        .o1_ey(o1_ey), .o1_eop(o1_eop)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    string xs [8];
    string ys [8];
    int qb [$];
    int mpos, mrate, e_n;
    int e_x [2], e_y [2], e_ex [2], e_ey [2], e_eop [2];

    task automatic chk(string tag, string fld, int lane, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s lane%0d %s got=%0d exp=%0d", tag, lane, fld, got, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "valid(R5)", 0, int'(o0_valid), int'(e_n > 0));
        chk(tag, "valid(R5)", 1, int'(o1_valid), int'(e_n > 1));
        if (e_n > 0 && o0_valid) begin
            chk(tag, "x(R2)",   0, int'(o0_x),   e_x[0]);
            chk(tag, "y(R2)",   0, int'(o0_y),   e_y[0]);
            chk(tag, "ex(R3)",  0, int'(o0_ex),  e_ex[0]);
            chk(tag, "ey(R3)",  0, int'(o0_ey),  e_ey[0]);
            chk(tag, "eop(R6)", 0, int'(o0_eop), e_eop[0]);
        end
        if (e_n > 1 && o1_valid) begin
            chk(tag, "x(R2)",   1, int'(o1_x),   e_x[1]);
            chk(tag, "y(R2)",   1, int'(o1_y),   e_y[1]);
            chk(tag, "ex(R3)",  1, int'(o1_ex),  e_ex[1]);
            chk(tag, "ey(R3)",  1, int'(o1_ey),  e_ey[1]);
            chk(tag, "eop(R6)", 1, int'(o1_eop), e_eop[1]);
        end
    endtask

    // behavioural model: queue of code bits consumed against the pattern strings
    task automatic model(bit v, int i, int q, int r, bit sw);
        e_n = 0;
        if (r != mrate) begin
            mrate = r;
            mpos  = 0;
            qb.delete();
        end else if (v) begin
            qb.push_back(sw ? q : i);
            qb.push_back(sw ? i : q);
            forever begin
                bit xp = (xs[r][mpos] == 8'h31);
                bit yp = (ys[r][mpos] == 8'h31);
                int need = int'(xp) + int'(yp);
                if (qb.size() < need) break;
                e_x[e_n]  = xp ? qb.pop_front() : ERASE;
                e_y[e_n]  = yp ? qb.pop_front() : ERASE;
                e_ex[e_n] = int'(!xp);
                e_ey[e_n] = int'(!yp);
                e_eop[e_n] = int'(mpos == xs[r].len() - 1);
                mpos = (mpos == xs[r].len() - 1) ? 0 : mpos + 1;
                e_n++;
            end
        end
    endtask

    task automatic cyc(bit v, int i, int q, int r, bit sw, string tag);
        @(negedge clk);
        compare(tag);
        in_valid = v;
        in_i     = 4'(i);
        in_q     = 4'(q);
        rate_sel = 3'(r);
        swap_iq  = sw;
        model(v, i, q, r, sw);
    endtask

    task automatic do_reset(int r, string tag);
        @(negedge clk);
        compare(tag);
        rst = 1'b1;
        rate_sel = 3'(r);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 in-reset", "valid(R5)", 0, int'(o0_valid), 0);
        rst   = 1'b0;
        mrate = r;
        mpos  = 0;
        qb.delete();
        e_n = 0;
    endtask

    initial begin
        xs = '{"1", "10", "101", "1000", "10101", "100101", "1000101", "10001011"};
        ys = '{"1", "11", "110", "1111", "11010", "111010", "1111010", "11110100"};
        mrate = 0; mpos = 0; e_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state visible on first compare
        cyc(0, 0, 0, 0, 0, "R9 reset");
        // R4: rate 1/2 straight mapping
        for (int n = 0; n < 40; n++)
            cyc(1, $urandom_range(15), $urandom_range(15), 0, 0, "R4 half");
        // R1/R2: every rate, continuous then gappy input
        for (int r = 1; r < 8; r++) begin
            for (int n = 0; n < 40; n++)
                cyc(1, $urandom_range(15), $urandom_range(15), r, 0, "R1 rate");
            for (int n = 0; n < 40; n++)
                cyc($urandom_range(3) != 0, $urandom_range(15), $urandom_range(15),
                    r, 0, "R2 order");
        end
        // R7: arm swap
        for (int n = 0; n < 60; n++)
            cyc(1, $urandom_range(15), $urandom_range(15), 2, bit'($urandom_range(1)),
                "R7 swap");
        // R8: rate changes mid-period
        begin
            int r = 6;
            for (int n = 0; n < 120; n++) begin
                if (n % 5 == 0) r = $urandom_range(7);
                cyc($urandom_range(4) != 0, $urandom_range(15), $urandom_range(15),
                    r, 0, "R8 change");
            end
        end
        // R10: idle gap holds the walk state
        for (int n = 0; n < 3; n++)
            cyc(1, $urandom_range(15), $urandom_range(15), 4, 0, "R10 idle");
        for (int n = 0; n < 20; n++)
            cyc(0, $urandom_range(15), $urandom_range(15), 4, 0, "R10 idle");
        for (int n = 0; n < 10; n++)
            cyc(1, $urandom_range(15), $urandom_range(15), 4, 0, "R10 idle");
        // R9: rate adopted during reset, no discarded symbol
        do_reset(6, "R10 idle");
        for (int n = 0; n < 30; n++)
            cyc(1, $urandom_range(15), $urandom_range(15), 6, 0, "R9 reset-rate");
        cyc(0, 0, 0, 6, 0, "R9 reset-rate");
        @(negedge clk);
        compare("R9 reset-rate");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(100000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule